// File: doc/BRIEF.md
# S/PDIF Channel-Status Block Capture

This block sits behind a biphase-mark decoder. For every decoded subframe it receives the channel-status bit, a tag that tells channel A from channel B, and a flag that marks the start of a block. A one-bit control picks the channel to follow. The block keeps only the status bits of that channel and builds a 192-bit status block in a working register. Bit 0 of the block is the first selected subframe at or after the block-start flag.

Once all 192 bits have arrived, the working register is copied in one step into a readable copy, and a one-cycle ready pulse goes out. Software reads the copy as six 32-bit words through a 3-bit word index. If a new start flag appears before a block is complete, the partial block is thrown away and the readable copy keeps the last complete block.

Top module: `chsts_capture`

## Requirements
- R1: After a synchronous reset, `status_word` reads zero for every index 0 to 7, and `blk_ready` is low.
- R2: Only subframes with `sf_valid` high and `sf_chan_b` equal to `chan_sel_b` add bits to the block. Tag 0 means channel A and tag 1 means channel B. A `chan_sel_b` of 0 follows channel A.
- R3: A selected subframe that carries `sf_blk_start` becomes bit 0. A start flag on a valid subframe of the other channel arms the capture, and the next selected subframe then becomes bit 0. This lets channel B align to a flag that arrives on channel A.
- R4: Block bit k (0 to 191, in arrival order) is read at word index k/32, bit position k mod 32. As a result, status byte n sits in word n/4, bits (n mod 4)×8+7 down to (n mod 4)×8, with its first-received bit in the lowest position.
- R5: Word indices 6 and 7 read as zero.
- R6: The readable copy changes only when the 192nd bit of an aligned block is received. `blk_ready` is high for exactly the one cycle after that bit's clock edge, and the new words are visible in that same cycle.
- R7: A start flag that arrives before 192 bits have been collected discards the partial block. Capture restarts at bit 0, the readable copy is left unchanged, and no ready pulse is issued.
- R8: Selected subframes are ignored in two cases: before the first start flag after reset, and after a block completes until the next start flag arrives.
- R9: While `sf_valid` is low, `sf_status`, `sf_chan_b` and `sf_blk_start` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sf_valid | input | 1 | One-cycle strobe for each decoded subframe |
| sf_status | input | 1 | Channel-status bit of the subframe |
| sf_chan_b | input | 1 | Subframe channel tag (0 = A, 1 = B) |
| sf_blk_start | input | 1 | Subframe carries the block-start preamble |
| chan_sel_b | input | 1 | Channel to capture (0 = A, 1 = B) |
| word_idx | input | 3 | Index of the status word to read |
| status_word | output | 32 | Selected word of the last complete block |
| blk_ready | output | 1 | One-cycle pulse when a new block is latched |

## Verification
A bad bit counter or a misplaced write index shows up as a status word that differs from the arithmetic pattern in the positions after the fault. It becomes visible only once the block completes, which is about 800 cycles after the stream starts. A wrongly armed or missed start flag either shifts every word by whole subframes or removes the ready pulse entirely. This is seen at the first readout after the expected pulse. A partial block that is latched by mistake, or a copy that changes between pulses, is caught by reading all six words right after an interrupted block and counting the pulses seen so far.

// File: rtl/chsts_pkg.sv
package chsts_pkg;

    localparam int BLOCK_BITS = 192;
    localparam int WORD_W     = 32;
    localparam int IDX_W      = 3;
    localparam int NUM_WORDS  = BLOCK_BITS / WORD_W;
    localparam int CNT_W      = $clog2(BLOCK_BITS);

    // One decoded subframe as seen by this block
    typedef struct packed {
        logic valid;
        logic status;
        logic chan_b;
        logic blk_start;
    } subframe_t;

    // One status bit accepted for the selected channel
    typedef struct packed {
        logic stb;
        logic value;
        logic first;
    } cs_bit_t;

    function automatic logic chan_match(input logic tag_b, input logic sel_b);
        return tag_b == sel_b;
    endfunction

endpackage

// File: rtl/chsts_chan_filter.sv
module chsts_chan_filter
    import chsts_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  subframe_t sf,
    input  logic      chan_sel_b,
    output cs_bit_t   cs_bit
);

    logic armed;
    logic hit;

    assign hit = sf.valid && chan_match(sf.chan_b, chan_sel_b);

    always_comb begin
        cs_bit.stb   = hit;
        cs_bit.value = sf.status;
        cs_bit.first = hit && (sf.blk_start || armed);
    end

    // A start flag seen on the other channel waits for the next selected subframe
    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
        end else if (hit) begin
            armed <= 1'b0;
        end else if (sf.valid && sf.blk_start) begin
            armed <= 1'b1;
        end
    end

    // R3
    arm_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> $past(sf.valid && sf.blk_start));

endmodule

// File: rtl/chsts_assembler.sv
module chsts_assembler
    import chsts_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  cs_bit_t               cs_bit,
    output logic                  done,
    output logic [BLOCK_BITS-1:0] full_block
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(BLOCK_BITS - 1);

    logic [BLOCK_BITS-1:0] shadow;
    logic [BLOCK_BITS-1:0] shadow_nx;
    logic [CNT_W-1:0]      cnt;
    logic                  in_sync;
    logic                  complete;

    always_comb begin
        shadow_nx      = shadow;
        shadow_nx[cnt] = cs_bit.value;
    end

    assign complete   = cs_bit.stb && !cs_bit.first && in_sync && (cnt == LAST);
    assign done       = complete;
    assign full_block = shadow_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow  <= '0;
            cnt     <= '0;
            in_sync <= 1'b0;
        end else if (cs_bit.stb) begin
            if (cs_bit.first) begin
                shadow    <= '0;
                shadow[0] <= cs_bit.value;
                cnt       <= CNT_W'(1);
                in_sync   <= 1'b1;
            end else if (in_sync) begin
                shadow <= shadow_nx;
                if (cnt == LAST) begin
                    cnt     <= '0;
                    in_sync <= 1'b0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R6
    count_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_bit.stb && !cs_bit.first && in_sync && cnt != LAST)
            |=> cnt == $past(cnt) + 1'b1);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_sync && !cs_bit.first) |=> $stable(cnt));

endmodule

// File: rtl/chsts_readout.sv
module chsts_readout
    import chsts_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [BLOCK_BITS-1:0] block_in,
    input  logic [IDX_W-1:0]      word_idx,
    output logic [WORD_W-1:0]     word_out,
    output logic                  ready
);

    logic [BLOCK_BITS-1:0] latched;

    always_ff @(posedge clk) begin
        if (rst) begin
            latched <= '0;
            ready   <= 1'b0;
        end else begin
            ready <= load;
            if (load) begin
                latched <= block_in;
            end
        end
    end

    always_comb begin
        word_out = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (word_idx == IDX_W'(w)) begin
                word_out = latched[w*WORD_W +: WORD_W];
            end
        end
    end

    // R6
    ready_single_chk: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);

    // R7
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ready |-> $stable(latched));

    // R5
    idx_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (word_idx >= IDX_W'(NUM_WORDS)) |-> word_out == '0);

endmodule

// File: rtl/chsts_capture.sv
module chsts_capture
    import chsts_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sf_valid,
    input  logic              sf_status,
    input  logic              sf_chan_b,
    input  logic              sf_blk_start,
    input  logic              chan_sel_b,
    input  logic [IDX_W-1:0]  word_idx,
    output logic [WORD_W-1:0] status_word,
    output logic              blk_ready
);

    subframe_t             sf;
    cs_bit_t               cs_bit;
    logic                  done;
    logic [BLOCK_BITS-1:0] full_block;

    always_comb begin
        sf.valid     = sf_valid;
        sf.status    = sf_status;
        sf.chan_b    = sf_chan_b;
        sf.blk_start = sf_blk_start;
    end

    chsts_chan_filter u_filter (
        .clk        (clk),
        .rst        (rst),
        .sf         (sf),
        .chan_sel_b (chan_sel_b),
        .cs_bit     (cs_bit)
    );

    chsts_assembler u_asm (
        .clk        (clk),
        .rst        (rst),
        .cs_bit     (cs_bit),
        .done       (done),
        .full_block (full_block)
    );

    chsts_readout u_rd (
        .clk      (clk),
        .rst      (rst),
        .load     (done),
        .block_in (full_block),
        .word_idx (word_idx),
        .word_out (status_word),
        .ready    (blk_ready)
    );

    // R9
    valid_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !sf_valid |=> !blk_ready);

endmodule

// File: tb/chsts_capture_test.sv
module chsts_capture_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sf_valid = 1'b0;
    logic        sf_status = 1'b0;
    logic        sf_chan_b = 1'b0;
    logic        sf_blk_start = 1'b0;
    logic        chan_sel_b = 1'b0;
    logic [2:0]  word_idx = 3'd0;
    logic [31:0] status_word;
    logic        blk_ready;

    int checks = 0;
    int fails  = 0;
    int rdy_cnt = 0;
    bit done_run = 0;

    always #2 clk = ~clk;

    chsts_capture uut (
        .clk(clk), .rst(rst), .sf_valid(sf_valid), .sf_status(sf_status),
        .sf_chan_b(sf_chan_b), .sf_blk_start(sf_blk_start),
        .chan_sel_b(chan_sel_b), .word_idx(word_idx),
        .status_word(status_word), .blk_ready(blk_ready)
    );

    always @(negedge clk) if (!rst && blk_ready) rdy_cnt++;

    function automatic logic pat(input int seed, input int k);
        int unsigned h;
        h = 32'(k) * 32'd40503 + 32'(seed) * 32'd7919 + 32'd12345;
        h = h ^ (h >> 7);
        return h[3] ^ h[9];
    endfunction

    function automatic logic [31:0] exp_word(input int seed, input int w);
        logic [31:0] r;
        r = '0;
        if (seed >= 0 && w < 6)
            for (int b = 0; b < 32; b++) r[b] = pat(seed, w*32 + b);
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // seed < 0 means every word reads zero
    task automatic check_words(input string req, input int seed);
        for (int w = 0; w < 8; w++) begin
            @(negedge clk);
            word_idx = 3'(w);
            #1;
            check(req, status_word, exp_word(seed, w));
        end
    endtask

    // Drives one subframe and then an idle cycle carrying garbage (R9)
    task automatic sub(input logic st, input logic chb, input logic start);
        @(negedge clk);
        sf_valid = 1'b1; sf_status = st; sf_chan_b = chb; sf_blk_start = start;
        @(negedge clk);
        sf_valid = 1'b0; sf_status = ~st; sf_chan_b = ~chb; sf_blk_start = 1'b1;
    endtask

    task automatic frames(input int sa, input int sb, input int n, input bit with_start);
        for (int k = 0; k < n; k++) begin
            sub(pat(sa, k), 1'b0, with_start && k == 0);
            sub(pat(sb, k), 1'b1, 1'b0);
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 ready", 32'(blk_ready), 32'd0);
        check_words("R1", -1);

        // R8: no start yet, bits ignored
        chan_sel_b = 1'b0;
        frames(9, 10, 20, 0);
        check("R8 no pulse before start", 32'(rdy_cnt), 32'd0);
        check_words("R8", -1);

        // R2 R4 R5 R6 R9: channel A block
        frames(1, 2, 192, 1);
        check("R6 one pulse", 32'(rdy_cnt), 32'd1);
        check_words("R4 chanA", 1);

        // R2 R3: channel B aligned to flag on channel A
        chan_sel_b = 1'b1;
        frames(3, 4, 192, 1);
        check("R6 second pulse", 32'(rdy_cnt), 32'd2);
        check_words("R3 chanB", 4);

        // R7: partial block discarded by early start
        frames(5, 6, 100, 1);
        check("R7 no pulse", 32'(rdy_cnt), 32'd2);
        check_words("R7 hold", 4);
        frames(7, 8, 192, 1);
        check("R7 restart pulse", 32'(rdy_cnt), 32'd3);
        check_words("R7 restart", 8);

        // R8: after a complete block, wait for next start
        frames(11, 12, 30, 0);
        check("R8 idle after block", 32'(rdy_cnt), 32'd3);
        check_words("R8 after", 8);
        chan_sel_b = 1'b0;
        frames(13, 14, 192, 1);
        check("R2 back to A", 32'(rdy_cnt), 32'd4);
        check_words("R2 chanA again", 13);

        // R1: reset clears readable copy
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        check_words("R1 rereset", -1);

        done_run = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done_run) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule